// File: doc/BRIEF.md
# SD/MMC Host Command Register Block

This block is the software-facing register file of a simplified SD/MMC host controller. Software stores the command argument, the block geometry and a buffer base address. It then writes a packed command word. That write hands the command to an abstract card engine over a valid/ready handshake. The block stays busy until the engine reports completion or a timeout.

On completion the block latches the card response into four 32-bit words. The response type carried in the command word decides how many of those words change. Completion, data-phase end, command timeout and card-state changes each raise a write-one-to-clear status bit. An enable mask gates these bits onto a single interrupt line. The card-present and write-protect inputs arrive asynchronously. They are synchronised, made readable, and any change on them raises a status bit.

Serial line signalling, CRC, clock division and the data mover all lie outside this block. The engine decodes the command word itself: bits 5:0 opcode, bit 6 open-drain, bits 9:8 response type, bit 11 busy wait, bits 13:12 command class, bit 15 read direction.

Top module: `sdh_cmd_regs`

## Requirements
- R1: After reset, status (0x00), enable (0x04), `irq_o`, `cmd_valid_o` and the busy flag all read 0.
- R2: The buffer base (0x08) and the argument (0x10) store all 32 bits. The enable register (0x04) stores bits 3:0. Block length (0x24) and block count (0x28) store bits 10:0, which hold the value minus one. All of these read back, upper bits read 0, and they drive `buf_base_o`, `cmd_arg_o`, `blk_len_o` and `blk_cnt_o`.
- R3: A write to the command register (0x0C) while idle stores bits 15:0. From the next cycle `cmd_valid_o` is high with that word on `cmd_word_o`, and it holds until a cycle with `cmd_ready_i` high. Busy (bit 31 of 0x2C) stays set until the engine reports done or timeout after the handoff.
- R4: A write to the command register while busy has no effect on the stored word, on `cmd_valid_o` or on the busy flag.
- R5: Engine done after handoff, without timeout, sets status bit 0 and latches the response according to command bits 9:8. Code 2 (long) loads words 0..3 (0x14, 0x18, 0x1C, 0x20) from response bits 31:0, 63:32, 95:64 and 127:96. Codes 1 and 3 load word 0 from bits 31:0 and clear words 1..3. Code 0 leaves all four words unchanged.
- R6: Engine timeout after handoff sets status bit 3, clears status bit 0, suppresses a done reported in the same cycle, keeps the response words and ends busy. Done or timeout reported while no command is outstanding is ignored.
- R7: A pulse on `eng_data_done_i` sets status bit 1.
- R8: Card state (0x2C) reports synchronised card present in bit 0 and write protect in bit 1. A change on either input shows in 0x2C two clock edges after the input changes. It sets status bit 2 one edge after that.
- R9: Writing 1 to a status bit clears it, and writing 0 leaves it. An event in the same cycle as the clear wins, so the bit stays set.
- R10: `irq_o` is high exactly when status AND enable is nonzero.
- R11: Reads of undefined or unaligned offsets return 0. Writes to the response words (0x14..0x20) and to card state (0x2C) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte offset of register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| cmd_valid_o | output | 1 | Command offered to engine |
| cmd_ready_i | input | 1 | Engine accepts command |
| cmd_word_o | output | 16 | Packed command word |
| cmd_arg_o | output | 32 | Command argument |
| blk_len_o | output | BLK_W | Block length minus one |
| blk_cnt_o | output | BLK_W | Block count minus one |
| buf_base_o | output | 32 | Data buffer base address |
| eng_done_i | input | 1 | Engine: command finished with response |
| eng_timeout_i | input | 1 | Engine: command timed out |
| eng_data_done_i | input | 1 | Engine: data phase finished |
| eng_resp_i | input | 32*RSP_WORDS | Engine response bits |
| card_present_i | input | 1 | Asynchronous card-inserted level |
| card_wp_i | input | 1 | Asynchronous write-protect level |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is a timeout and a done arriving in the same cycle while an earlier done bit is still pending, because the timeout must both clear the old bit and suppress the new one. The bench leaves status bit 0 set on purpose from a previous completion, launches a command, completes the handshake and then pulses both engine inputs on one edge. The same-cycle race between a software clear and a hardware set is reached by placing a status write and a data-done pulse on the same edge. The synchroniser latency is checked on both sides of the expected edge.

// File: rtl/sdh_pkg.sv
package sdh_pkg;
    localparam int unsigned REG_AW  = 8;
    localparam int unsigned CMD_W   = 16;
    localparam int unsigned NUM_EVT = 4;

    localparam logic [REG_AW-1:0] OFS_STAT = 8'h00;
    localparam logic [REG_AW-1:0] OFS_IEN  = 8'h04;
    localparam logic [REG_AW-1:0] OFS_BUF  = 8'h08;
    localparam logic [REG_AW-1:0] OFS_CMD  = 8'h0C;
    localparam logic [REG_AW-1:0] OFS_ARG  = 8'h10;
    localparam logic [REG_AW-1:0] OFS_RSP0 = 8'h14;
    localparam logic [REG_AW-1:0] OFS_BLEN = 8'h24;
    localparam logic [REG_AW-1:0] OFS_BCNT = 8'h28;
    localparam logic [REG_AW-1:0] OFS_CARD = 8'h2C;

    // status bit positions
    localparam int unsigned EV_CMD  = 0;
    localparam int unsigned EV_DATA = 1;
    localparam int unsigned EV_CARD = 2;
    localparam int unsigned EV_TOUT = 3;

    typedef enum logic [1:0] {
        RSP_NONE  = 2'd0,
        RSP_SHORT = 2'd1,
        RSP_LONG  = 2'd2,
        RSP_OCR   = 2'd3
    } rsp_kind_e;
endpackage

// File: rtl/sdh_sync.sv
module sdh_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o,
    output logic             changed_o
);
    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] chain;
        logic [WIDTH-1:0]             prev;
    } sync_t;

    sync_t s_d, s_q;

    assign sync_o    = s_q.chain[STAGES-1];
    assign changed_o = (s_q.chain[STAGES-1] != s_q.prev);

    always_comb begin
        s_d          = s_q;
        s_d.chain[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            s_d.chain[i] = s_q.chain[i-1];
        end
        s_d.prev = s_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/sdh_irq_status.sv
module sdh_irq_status #(
    parameter int unsigned N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic         cancel_i,
    input  logic         clr_we_i,
    input  logic [N-1:0] clr_mask_i,
    input  logic [N-1:0] en_i,
    output logic [N-1:0] status_o,
    output logic         irq_o
);
    logic [N-1:0] stat_d, stat_q;

    always_comb begin
        stat_d = stat_q;
        if (clr_we_i) stat_d = stat_d & ~clr_mask_i;
        if (cancel_i) stat_d[0] = 1'b0;
        stat_d = stat_d | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_d;
    end

    assign status_o = stat_q;
    assign irq_o    = |(stat_q & en_i);

    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((stat_q & $past(set_i)) == $past(set_i)));

    p_w1c_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we_i && |(clr_mask_i & ~set_i)) |=>
        ((stat_q & $past(clr_mask_i & ~set_i)) == '0));

    p_cancel_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cancel_i && !set_i[0]) |=> !stat_q[0]);
endmodule

// File: rtl/sdh_cmd_regs.sv
module sdh_cmd_regs
    import sdh_pkg::*;
#(
    parameter int unsigned BLK_W       = 11,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned RSP_WORDS   = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    reg_we,
    input  logic [REG_AW-1:0]       reg_addr,
    input  logic [31:0]             reg_wdata,
    output logic [31:0]             reg_rdata,
    output logic                    cmd_valid_o,
    input  logic                    cmd_ready_i,
    output logic [CMD_W-1:0]        cmd_word_o,
    output logic [31:0]             cmd_arg_o,
    output logic [BLK_W-1:0]        blk_len_o,
    output logic [BLK_W-1:0]        blk_cnt_o,
    output logic [31:0]             buf_base_o,
    input  logic                    eng_done_i,
    input  logic                    eng_timeout_i,
    input  logic                    eng_data_done_i,
    input  logic [32*RSP_WORDS-1:0] eng_resp_i,
    input  logic                    card_present_i,
    input  logic                    card_wp_i,
    output logic                    irq_o
);
    typedef struct packed {
        logic [NUM_EVT-1:0]               en;
        logic [31:0]                      bufb;
        logic [31:0]                      arg;
        logic [CMD_W-1:0]                 cmd;
        logic [BLK_W-1:0]                 blen;
        logic [BLK_W-1:0]                 bcnt;
        logic [RSP_WORDS-1:0][31:0]       resp;
        logic                             valid;
        logic                             busy;
    } regs_t;

    regs_t r_d, r_q;

    logic [1:0]         card_s;
    logic               card_chg;
    logic [NUM_EVT-1:0] status;
    logic [NUM_EVT-1:0] evt_set;
    logic               issued, done_ok, tout_ok, wr_cmd, clr_we;

    sdh_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .async_i   ({card_wp_i, card_present_i}),
        .sync_o    (card_s),
        .changed_o (card_chg)
    );

    assign issued  = r_q.busy && !r_q.valid;
    assign tout_ok = issued && eng_timeout_i;
    assign done_ok = issued && eng_done_i && !eng_timeout_i;
    assign wr_cmd  = reg_we && (reg_addr == OFS_CMD);
    assign clr_we  = reg_we && (reg_addr == OFS_STAT);

    always_comb begin
        evt_set          = '0;
        evt_set[EV_CMD]  = done_ok;
        evt_set[EV_DATA] = eng_data_done_i;
        evt_set[EV_CARD] = card_chg;
        evt_set[EV_TOUT] = tout_ok;
    end

    sdh_irq_status #(.N(NUM_EVT)) u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (evt_set),
        .cancel_i   (tout_ok),
        .clr_we_i   (clr_we),
        .clr_mask_i (reg_wdata[NUM_EVT-1:0]),
        .en_i       (r_q.en),
        .status_o   (status),
        .irq_o      (irq_o)
    );

    always_comb begin
        r_d = r_q;
        if (reg_we) begin
            case (reg_addr)
                OFS_IEN:  r_d.en   = reg_wdata[NUM_EVT-1:0];
                OFS_BUF:  r_d.bufb = reg_wdata;
                OFS_ARG:  r_d.arg  = reg_wdata;
                OFS_BLEN: r_d.blen = reg_wdata[BLK_W-1:0];
                OFS_BCNT: r_d.bcnt = reg_wdata[BLK_W-1:0];
                default:  ;
            endcase
        end
        if (wr_cmd && !r_q.busy) begin
            r_d.cmd   = reg_wdata[CMD_W-1:0];
            r_d.valid = 1'b1;
            r_d.busy  = 1'b1;
        end
        if (r_q.valid && cmd_ready_i) r_d.valid = 1'b0;
        if (tout_ok || done_ok)       r_d.busy  = 1'b0;
        if (done_ok) begin
            case (rsp_kind_e'(r_q.cmd[9:8]))
                RSP_LONG: begin
                    for (int i = 0; i < RSP_WORDS; i++)
                        r_d.resp[i] = eng_resp_i[32*i +: 32];
                end
                RSP_SHORT, RSP_OCR: begin
                    for (int i = 1; i < RSP_WORDS; i++)
                        r_d.resp[i] = '0;
                    r_d.resp[0] = eng_resp_i[31:0];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_STAT: reg_rdata[NUM_EVT-1:0] = status;
            OFS_IEN:  reg_rdata[NUM_EVT-1:0] = r_q.en;
            OFS_BUF:  reg_rdata = r_q.bufb;
            OFS_CMD:  reg_rdata[CMD_W-1:0] = r_q.cmd;
            OFS_ARG:  reg_rdata = r_q.arg;
            OFS_BLEN: reg_rdata[BLK_W-1:0] = r_q.blen;
            OFS_BCNT: reg_rdata[BLK_W-1:0] = r_q.bcnt;
            OFS_CARD: reg_rdata = {r_q.busy, 29'd0, card_s};
            default:  ;
        endcase
        for (int i = 0; i < RSP_WORDS; i++) begin
            if (reg_addr == OFS_RSP0 + REG_AW'(4*i)) reg_rdata = r_q.resp[i];
        end
    end

    assign cmd_valid_o = r_q.valid;
    assign cmd_word_o  = r_q.cmd;
    assign cmd_arg_o   = r_q.arg;
    assign blk_len_o   = r_q.blen;
    assign blk_cnt_o   = r_q.bcnt;
    assign buf_base_o  = r_q.bufb;

    p_offer_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && !cmd_ready_i) |=> (cmd_valid_o && $stable(cmd_word_o)));

    p_valid_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |-> r_q.busy);

    p_busy_ignore_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd && r_q.busy) |=> $stable(cmd_word_o));

    p_tout_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (issued && eng_timeout_i) |=> (!r_q.busy && !cmd_valid_o));

    p_long_resp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_ok && r_q.cmd[9:8] == 2'd2) |=> (r_q.resp[0] == $past(eng_resp_i[31:0])));
endmodule

// File: tb/sim_sdh_cmd_regs.sv
module sim_sdh_cmd_regs;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_we = 1'b0;
    logic [7:0]   reg_addr = '0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic         cmd_valid_o;
    logic         cmd_ready_i = 1'b0;
    logic [15:0]  cmd_word_o;
    logic [31:0]  cmd_arg_o;
    logic [10:0]  blk_len_o, blk_cnt_o;
    logic [31:0]  buf_base_o;
    logic         eng_done_i = 1'b0, eng_timeout_i = 1'b0, eng_data_done_i = 1'b0;
    logic [127:0] eng_resp_i = '0;
    logic         card_present_i = 1'b0, card_wp_i = 1'b0;
    logic         irq_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    sdh_cmd_regs u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmd_valid_o(cmd_valid_o),
        .cmd_ready_i(cmd_ready_i), .cmd_word_o(cmd_word_o), .cmd_arg_o(cmd_arg_o),
        .blk_len_o(blk_len_o), .blk_cnt_o(blk_cnt_o), .buf_base_o(buf_base_o),
        .eng_done_i(eng_done_i), .eng_timeout_i(eng_timeout_i),
        .eng_data_done_i(eng_data_done_i), .eng_resp_i(eng_resp_i),
        .card_present_i(card_present_i), .card_wp_i(card_wp_i), .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic rdchk(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic eng(input logic dn, input logic to, input logic dd, input logic [127:0] rs);
        @(negedge clk);
        eng_done_i = dn; eng_timeout_i = to; eng_data_done_i = dd; eng_resp_i = rs;
        @(negedge clk);
        eng_done_i = 1'b0; eng_timeout_i = 1'b0; eng_data_done_i = 1'b0;
    endtask

    task automatic launch(input logic [31:0] w);
        wr(8'h0C, w);
        cmd_ready_i = 1'b1;
        @(negedge clk);
        cmd_ready_i = 1'b0;
    endtask

    task automatic t_reset;
        rdchk("R1 status", 8'h00, 32'h0);
        rdchk("R1 enable", 8'h04, 32'h0);
        rdchk("R1 card/busy", 8'h2C, 32'h0);
        chk("R1 irq", {31'd0, irq_o}, 32'h0);
        chk("R1 valid", {31'd0, cmd_valid_o}, 32'h0);
    endtask

    task automatic t_regs;
        wr(8'h08, 32'hCAFE_0040);
        rdchk("R2 buf", 8'h08, 32'hCAFE_0040);
        chk("R2 buf out", buf_base_o, 32'hCAFE_0040);
        wr(8'h24, 32'hFFFF_FFFF);
        rdchk("R2 blen", 8'h24, 32'h7FF);
        chk("R2 blen out", {21'd0, blk_len_o}, 32'h7FF);
        wr(8'h28, 32'h0000_0801);
        rdchk("R2 bcnt", 8'h28, 32'h1);
        chk("R2 bcnt out", {21'd0, blk_cnt_o}, 32'h1);
        wr(8'h04, 32'hFF);
        rdchk("R2 enable", 8'h04, 32'hF);
        wr(8'h04, 32'h0);
    endtask

    task automatic t_launch;
        wr(8'h10, 32'hA5A5_0001);
        chk("R2 arg out", cmd_arg_o, 32'hA5A5_0001);
        wr(8'h0C, 32'hFFFF_9A11);
        chk("R3 valid", {31'd0, cmd_valid_o}, 32'h1);
        chk("R3 word", {16'd0, cmd_word_o}, 32'h9A11);
        rdchk("R3 cmd read", 8'h0C, 32'h9A11);
        rdchk("R3 busy", 8'h2C, 32'h8000_0000);
        repeat (3) @(negedge clk);
        chk("R3 held", {31'd0, cmd_valid_o}, 32'h1);
        cmd_ready_i = 1'b1;
        @(negedge clk);
        cmd_ready_i = 1'b0;
        chk("R3 dropped", {31'd0, cmd_valid_o}, 32'h0);
        rdchk("R3 still busy", 8'h2C, 32'h8000_0000);
    endtask

    task automatic t_busy_long;
        wr(8'h0C, 32'h0000_0042);
        rdchk("R4 word kept", 8'h0C, 32'h9A11);
        chk("R4 no offer", {31'd0, cmd_valid_o}, 32'h0);
        eng(1'b1, 1'b0, 1'b0, 128'h4444_4444_3333_3333_2222_2222_1111_1111);
        rdchk("R5 long w0", 8'h14, 32'h1111_1111);
        rdchk("R5 long w1", 8'h18, 32'h2222_2222);
        rdchk("R5 long w2", 8'h1C, 32'h3333_3333);
        rdchk("R5 long w3", 8'h20, 32'h4444_4444);
        rdchk("R5 done bit", 8'h00, 32'h1);
        rdchk("R3 idle", 8'h2C, 32'h0);
        wr(8'h00, 32'h1);
        rdchk("R9 cleared", 8'h00, 32'h0);
    endtask

    task automatic t_short;
        launch(32'h0111);
        eng(1'b1, 1'b0, 1'b0, 128'hDDDD_DDDD_CCCC_CCCC_BBBB_BBBB_0000_AAAA);
        rdchk("R5 short w0", 8'h14, 32'h0000_AAAA);
        rdchk("R5 short w1", 8'h18, 32'h0);
        rdchk("R5 short w3", 8'h20, 32'h0);
        launch(32'h0005);
        eng(1'b1, 1'b0, 1'b0, 128'h9999_9999_8888_8888_7777_7777_6666_6666);
        rdchk("R5 none keeps w0", 8'h14, 32'h0000_AAAA);
        rdchk("R5 none done", 8'h00, 32'h1);
    endtask

    task automatic t_timeout;
        launch(32'h0102);
        eng(1'b1, 1'b1, 1'b0, 128'h5555_5555);
        rdchk("R6 tout only", 8'h00, 32'h8);
        rdchk("R6 not busy", 8'h2C, 32'h0);
        rdchk("R6 resp kept", 8'h14, 32'h0000_AAAA);
        eng(1'b1, 1'b0, 1'b0, 128'h1);
        rdchk("R6 idle done ignored", 8'h00, 32'h8);
        rdchk("R6 idle resp kept", 8'h14, 32'h0000_AAAA);
        wr(8'h00, 32'hF);
    endtask

    task automatic t_data;
        eng(1'b0, 1'b0, 1'b1, 128'h0);
        rdchk("R7 data bit", 8'h00, 32'h2);
    endtask

    task automatic t_w1c;
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 8'h00; reg_wdata = 32'h2; eng_data_done_i = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; eng_data_done_i = 1'b0;
        rdchk("R9 set wins", 8'h00, 32'h2);
        wr(8'h00, 32'h0);
        rdchk("R9 zero keeps", 8'h00, 32'h2);
    endtask

    task automatic t_irq;
        chk("R10 masked", {31'd0, irq_o}, 32'h0);
        wr(8'h04, 32'h1);
        chk("R10 other bit", {31'd0, irq_o}, 32'h0);
        wr(8'h04, 32'h2);
        chk("R10 enabled", {31'd0, irq_o}, 32'h1);
        wr(8'h00, 32'h2);
        chk("R10 cleared", {31'd0, irq_o}, 32'h0);
        wr(8'h04, 32'h0);
    endtask

    task automatic t_card;
        @(negedge clk);
        card_present_i = 1'b1; card_wp_i = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        rdchk("R8 state", 8'h2C, 32'h3);
        rdchk("R8 not yet", 8'h00, 32'h0);
        @(negedge clk);
        rdchk("R8 change bit", 8'h00, 32'h4);
    endtask

    task automatic t_undef;
        rdchk("R11 hole", 8'h30, 32'h0);
        rdchk("R11 unaligned", 8'h02, 32'h0);
        wr(8'h14, 32'hDEAD_BEEF);
        rdchk("R11 resp ro", 8'h14, 32'h0000_AAAA);
        wr(8'h2C, 32'h0);
        rdchk("R11 state ro", 8'h2C, 32'h3);
    endtask

    initial begin
        #200000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_launch();
        t_busy_long();
        t_short();
        t_timeout();
        t_data();
        t_w1c();
        t_irq();
        t_card();
        t_undef();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule